// File: doc/BRIEF.md
# Banked Subtract-With-Borrow Datapath

This block carries out one register-file arithmetic instruction over a four-phase machine cycle. The instruction computes the working register minus a data-memory operand minus the carry flag. In the first phase it decodes a 16-bit instruction word and forms a 12-bit data-memory address. The address comes either from a fixed access window or from a 4-bit bank number joined to the 8-bit file address. In the second phase it reads the operand. In the third phase it computes an 8-bit difference and five status flags. In the fourth phase it writes the difference to the working register or back to the same memory location.

The surrounding core supplies the phase count, the working register value, the bank number and the carry flag. It also provides a 4096-byte data memory with a combinational read port and a write port. The block raises write strobes only during the fourth phase, so the core can commit the working register, the memory byte and the flags at the end of the cycle. The operands are held in registers from the second phase onward. Because of this, an instruction that writes back into its own source location sees consistent data.

Top module: `swb_datapath`

## Requirements
- R1: Only an instruction word whose bits 15..10 equal 010101 is executed. Any other word raises none of `wr_en`, `wreg_we` or `flags_we` in its fourth phase.
- R2: `result` equals (working register − memory operand − carry) modulo 256.
- R3: Bit 9 of the instruction selects the destination. When it is 0, only `wreg_we` is raised. When it is 1, only `wr_en` is raised, with `wr_addr` equal to the address that was read and `wr_data` equal to `result`. The two strobes are never high together.
- R4: When bit 8 is 0, the access window is used and `bsr` is ignored. File addresses 0x00–0x7F map to 0x000–0x07F, and 0x80–0xFF map to 0xF80–0xFFF. When bit 8 is 1, the address is {`bsr`, bits 7..0}.
- R5: `flag_c` is 1 exactly when the full 8-bit subtraction needs no borrow. `flag_dc` is 1 exactly when the subtraction of the low four bits, including the carry, needs no borrow.
- R6: `flag_z` is 1 exactly when `result` is zero. `flag_n` equals bit 7 of `result`.
- R7: `flag_ov` is 1 exactly when the signed value (working register − operand − carry) lies outside −128..127.
- R8: Phase encoding is 0,1,2,3 for phases one to four. `rd_addr` holds the operand address during phase two. `wr_en`, `wreg_we` and `flags_we` are high only during phase four of an executed instruction.
- R9: The operands, carry and destination are fixed at the end of phases one and two. Changing `instr`, `bsr`, `wreg` or `carry_in` during phase three does not alter `result`, the flags or the strobes.
- R10: After reset, every strobe is low, and `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per phase |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase | input | 2 | Phase count within the instruction cycle (0..3) |
| instr | input | 16 | Instruction word, decoded in phase 0 |
| wreg | input | 8 | Working register value |
| bsr | input | 4 | Bank number for banked addressing |
| carry_in | input | 1 | Carry flag subtracted as borrow-in |
| rd_addr | output | 12 | Data-memory read address |
| rd_data | input | 8 | Data-memory read data |
| wr_addr | output | 12 | Data-memory write address |
| wr_data | output | 8 | Data-memory write data |
| wr_en | output | 1 | Data-memory write strobe |
| wreg_we | output | 1 | Working-register write strobe |
| result | output | 8 | Computed difference |
| flags_we | output | 1 | Status-flag update strobe |
| flag_n | output | 1 | Negative flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_c | output | 1 | No-borrow flag, bit 7 |
| flag_dc | output | 1 | No-borrow flag, bit 3 |
| flag_z | output | 1 | Zero flag |

## Verification
Some properties are checked on every cycle. Strobes appear only in phase four, and the two destination strobes are exclusive. A memory write-back targets the address that was read. Captured operands stay still through phase four. The access window never produces an address outside its two 128-byte ranges, and a banked address carries the bank number. Operands of the same sign never report overflow. The arithmetic itself can only be shown by the bench's scenarios: the difference and the carry, digit-carry and overflow values across sign and borrow corners. So can ignoring foreign opcodes and immunity to late input changes.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int INSTR_W  = 16;
    localparam int OPC_W    = 6;
    localparam int OPC_LSB  = 10;
    localparam int DEST_BIT = 9;
    localparam int BANK_BIT = 8;
    localparam logic [OPC_W-1:0] SWB_OPCODE = 6'b010101;
    localparam int NIBBLE_W = 4;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    typedef struct packed {
        logic n;
        logic ov;
        logic c;
        logic dc;
        logic z;
    } flags_t;

endpackage

// File: rtl/swb_decode.sv
module swb_decode
    import swb_pkg::*;
#(
    parameter int FADDR_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               hit,
    output logic               dest_f,
    output logic               banked,
    output logic [FADDR_W-1:0] faddr
);

    always_comb begin
        hit    = (instr[INSTR_W-1:OPC_LSB] == SWB_OPCODE);
        dest_f = instr[DEST_BIT];
        banked = instr[BANK_BIT];
        faddr  = instr[FADDR_W-1:0];
    end

endmodule

// File: rtl/swb_addr_gen.sv
module swb_addr_gen #(
    parameter int FADDR_W = 8,
    parameter int BANK_W  = 4,
    localparam int ADDR_W = BANK_W + FADDR_W
) (
    input  logic               banked,
    input  logic [BANK_W-1:0]  bsr,
    input  logic [FADDR_W-1:0] faddr,
    output logic [ADDR_W-1:0]  addr
);

    // access window: lower half of f -> bottom of memory, upper half -> top
    logic [BANK_W-1:0] window_bank;

    always_comb begin
        window_bank = {BANK_W{faddr[FADDR_W-1]}};
        if (banked) begin
            addr = {bsr, faddr};
        end else begin
            addr = {window_bank, faddr};
        end
    end

endmodule

// File: rtl/swb_sub_core.sv
module swb_sub_core
    import swb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd_w,
    input  logic [DATA_W-1:0] opnd_f,
    input  logic              cin,
    output logic [DATA_W-1:0] diff,
    output flags_t            flags
);

    localparam int NIB = NIBBLE_W;

    logic [DATA_W:0] w_ext;
    logic [DATA_W:0] sub_ext;
    logic [NIB:0]    w_low;
    logic [NIB:0]    sub_low;

    always_comb begin
        w_ext   = {1'b0, opnd_w};
        sub_ext = {1'b0, opnd_f} + {{DATA_W{1'b0}}, cin};
        w_low   = {1'b0, opnd_w[NIB-1:0]};
        sub_low = {1'b0, opnd_f[NIB-1:0]} + {{NIB{1'b0}}, cin};

        diff     = opnd_w - opnd_f - {{(DATA_W-1){1'b0}}, cin};
        flags.c  = (w_ext >= sub_ext);
        flags.dc = (w_low >= sub_low);
        flags.n  = diff[DATA_W-1];
        flags.z  = (diff == '0);
        flags.ov = (opnd_w[DATA_W-1] ^ opnd_f[DATA_W-1]) &
                   (opnd_w[DATA_W-1] ^ diff[DATA_W-1]);
    end

    // R7: like-signed operands cannot leave the signed range
    always_comb begin
        if (opnd_w[DATA_W-1] == opnd_f[DATA_W-1]) begin
            assert_no_ov_same_sign_R7: assert (!flags.ov);
        end
    end

endmodule

// File: rtl/swb_datapath.sv
module swb_datapath
    import swb_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FADDR_W = 8,
    parameter int BANK_W  = 4,
    localparam int ADDR_W = BANK_W + FADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           phase,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    wreg,
    input  logic [BANK_W-1:0]    bsr,
    input  logic                 carry_in,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 wr_en,
    output logic                 wreg_we,
    output logic [DATA_W-1:0]    result,
    output logic                 flags_we,
    output logic                 flag_n,
    output logic                 flag_ov,
    output logic                 flag_c,
    output logic                 flag_dc,
    output logic                 flag_z
);

    typedef struct packed {
        logic              valid;
        logic              dest_f;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] opnd_w;
        logic [DATA_W-1:0] opnd_f;
        logic              cin;
        logic [DATA_W-1:0] result;
        flags_t            flags;
    } state_t;

    phase_e             ph;
    logic               dec_hit;
    logic               dec_dest_f;
    logic               dec_banked;
    logic [FADDR_W-1:0] dec_faddr;
    logic [ADDR_W-1:0]  gen_addr;
    logic [DATA_W-1:0]  core_diff;
    flags_t             core_flags;
    state_t             st_d;
    state_t             st_q;

    assign ph = phase_e'(phase);

    swb_decode #(.FADDR_W(FADDR_W)) u_decode (
        .instr  (instr),
        .hit    (dec_hit),
        .dest_f (dec_dest_f),
        .banked (dec_banked),
        .faddr  (dec_faddr)
    );

    swb_addr_gen #(.FADDR_W(FADDR_W), .BANK_W(BANK_W)) u_addr_gen (
        .banked (dec_banked),
        .bsr    (bsr),
        .faddr  (dec_faddr),
        .addr   (gen_addr)
    );

    swb_sub_core #(.DATA_W(DATA_W)) u_sub_core (
        .opnd_w (st_q.opnd_w),
        .opnd_f (st_q.opnd_f),
        .cin    (st_q.cin),
        .diff   (core_diff),
        .flags  (core_flags)
    );

    always_comb begin
        st_d = st_q;
        unique case (ph)
            PH_Q1: begin
                st_d.valid  = dec_hit;
                st_d.dest_f = dec_dest_f;
                st_d.addr   = gen_addr;
            end
            PH_Q2: begin
                if (st_q.valid) begin
                    st_d.opnd_w = wreg;
                    st_d.opnd_f = rd_data;
                    st_d.cin    = carry_in;
                end
            end
            PH_Q3: begin
                if (st_q.valid) begin
                    st_d.result = core_diff;
                    st_d.flags  = core_flags;
                end
            end
            PH_Q4: begin
                st_d = st_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_addr  = st_q.addr;
        wr_addr  = st_q.addr;
        wr_data  = st_q.result;
        result   = st_q.result;
        wr_en    = st_q.valid &&  st_q.dest_f && (ph == PH_Q4);
        wreg_we  = st_q.valid && !st_q.dest_f && (ph == PH_Q4);
        flags_we = st_q.valid && (ph == PH_Q4);
        flag_n   = st_q.flags.n;
        flag_ov  = st_q.flags.ov;
        flag_c   = st_q.flags.c;
        flag_dc  = st_q.flags.dc;
        flag_z   = st_q.flags.z;
    end

    assert_strobe_q4_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || wreg_we || flags_we) |-> (ph == PH_Q4));

    assert_one_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wreg_we));

    assert_wb_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == $past(rd_addr)));

    assert_window_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1 && dec_hit && !dec_banked) |->
        (gen_addr[ADDR_W-1:FADDR_W] == '0 || gen_addr[ADDR_W-1:FADDR_W] == '1));

    assert_bank_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q1 && dec_hit && dec_banked) |->
        (gen_addr[ADDR_W-1:FADDR_W] == bsr));

    assert_operand_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_Q4) |->
        ($stable(st_q.opnd_w) && $stable(st_q.opnd_f) && $stable(st_q.cin)));

endmodule

// File: tb/tb_swb_datapath.sv
`timescale 1ns/1ps
module tb_swb_datapath;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  phase;
    logic [15:0] instr;
    logic [7:0]  wreg;
    logic [3:0]  bsr;
    logic        carry_in;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        wreg_we;
    logic [7:0]  result;
    logic        flags_we;
    logic        flag_n, flag_ov, flag_c, flag_dc, flag_z;

    logic [7:0]  mem [0:4095];
    int          vectors = 0;
    int          miscompares = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    swb_datapath dut (
        .clk(clk), .rst_n(rst_n), .phase(phase), .instr(instr), .wreg(wreg),
        .bsr(bsr), .carry_in(carry_in), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .wreg_we(wreg_we),
        .result(result), .flags_we(flags_we), .flag_n(flag_n), .flag_ov(flag_ov),
        .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int calc_addr(input logic [15:0] ins, input logic [3:0] b);
        int f = int'(ins[7:0]);
        if (ins[8]) return int'(b) * 256 + f;
        if (f >= 128) return 3840 + f;
        return f;
    endfunction

    task automatic run_instr(input logic [15:0] ins, input logic [7:0] w,
                             input logic c, input logic [3:0] b, input bit corrupt);
        int addr, fv, wi, ci, diff, sw, sf, sres, e_res;
        bit hit, d;
        hit  = (ins[15:10] == 6'b010101);
        d    = ins[9];
        addr = calc_addr(ins, b);
        fv   = int'(mem[addr]);
        wi   = int'(w);
        ci   = c ? 1 : 0;
        diff = wi - fv - ci;
        e_res = diff & 255;
        sw   = (wi > 127) ? wi - 256 : wi;
        sf   = (fv > 127) ? fv - 256 : fv;
        sres = sw - sf - ci;

        phase = 2'd0; instr = ins; wreg = w; carry_in = c; bsr = b;
        @(posedge clk); @(negedge clk);
        phase = 2'd1; #1;
        if (hit) chk("R8 rd_addr in phase two", int'(rd_addr), addr);
        chk("R8 no strobe in phase two", int'({wr_en, wreg_we, flags_we}), 0);
        @(posedge clk); @(negedge clk);
        phase = 2'd2;
        if (corrupt) begin
            instr = ~ins; wreg = ~w; carry_in = ~c; bsr = ~b;
        end
        #1;
        chk("R8 no strobe in phase three", int'({wr_en, wreg_we, flags_we}), 0);
        @(posedge clk); @(negedge clk);
        phase = 2'd3; #1;
        if (!hit) begin
            chk("R1 foreign opcode strobes", int'({wr_en, wreg_we, flags_we}), 0);
        end else begin
            chk(corrupt ? "R9 result after late input change" : "R2 result",
                int'(result), e_res);
            chk("R5 flag_c", int'(flag_c), (diff >= 0) ? 1 : 0);
            chk("R5 flag_dc", int'(flag_dc), ((wi % 16) - (fv % 16) - ci >= 0) ? 1 : 0);
            chk("R6 flag_z", int'(flag_z), (e_res == 0) ? 1 : 0);
            chk("R6 flag_n", int'(flag_n), (e_res >= 128) ? 1 : 0);
            chk("R7 flag_ov", int'(flag_ov), (sres < -128 || sres > 127) ? 1 : 0);
            chk("R8 flags_we in phase four", int'(flags_we), 1);
            chk("R3 destination strobes", int'({wr_en, wreg_we}), d ? 2 : 1);
            if (d) begin
                chk("R3 write-back address", int'(wr_addr), addr);
                chk("R3 write-back data", int'(wr_data), e_res);
            end
        end
        if (wr_en) mem[wr_addr] = wr_data;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] corners [10] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F,
                                     8'h80, 8'h81, 8'hF0, 8'hFE, 8'hFF};
        for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 37 + 11) & 255);
        rst_n = 1'b0; phase = 2'd3; instr = '0; wreg = '0; bsr = '0; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 strobes in reset", int'({wr_en, wreg_we, flags_we}), 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R10 result after reset", int'(result), 0);
        chk("R10 flags after reset", int'({flag_n, flag_ov, flag_c, flag_dc, flag_z}), 0);
        chk("R10 strobes after reset", int'({wr_en, wreg_we, flags_we}), 0);
        @(negedge clk);

        // R4: access window edges and banked mapping
        mem[12'h07F] = 8'h05; mem[12'hF80] = 8'h06; mem[12'hA80] = 8'h07;
        run_instr(16'h547F, 8'h10, 1'b0, 4'hA, 1'b0);
        run_instr(16'h5480, 8'h10, 1'b0, 4'hA, 1'b0);
        run_instr(16'h5580, 8'h10, 1'b0, 4'hA, 1'b0);
        run_instr(16'h56FF, 8'h00, 1'b1, 4'h3, 1'b0);

        // corner operand sweep, both destinations and carries
        for (int wi = 0; wi < 10; wi++) begin
            for (int fi = 0; fi < 10; fi++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int di = 0; di < 2; di++) begin
                        logic [15:0] ins;
                        logic [3:0]  b;
                        b   = 4'(wi);
                        ins = {6'b010101, 1'(di), 1'(fi % 2), 8'((wi * 10 + fi) * 3)};
                        mem[calc_addr(ins, b)] = corners[fi];
                        run_instr(ins, corners[wi], 1'(ci), b, 1'b0);
                    end
                end
            end
        end

        // R1: foreign opcodes
        for (int k = 0; k < 200; k++) begin
            logic [31:0] r;
            logic [15:0] ins;
            r = $urandom();
            ins = r[15:0];
            if (ins[15:10] == 6'b010101) ins[12] = ~ins[12];
            run_instr(ins, r[23:16], r[24], r[28:25], 1'b0);
        end

        // R9: late changes to inputs are ignored
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r;
            r = $urandom();
            run_instr({6'b010101, r[9:0]}, r[17:10], r[18], r[22:19], 1'b1);
        end

        // R2: pseudo-random operands and addressing
        for (int k = 0; k < 24000; k++) begin
            logic [31:0] r;
            r = $urandom();
            run_instr({6'b010101, r[9:0]}, r[17:10], r[18], r[22:19], 1'b0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule